// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a synthesizable model of a flow-through synchronous burst static RAM. Every rising clock edge captures the address, the three chip selects, the write controls and the burst controls. Either of two load strobes starts an access at an external address. One strobe is meant for a processor and the other for a memory controller. After a load, an advance input steps a 2-bit burst counter through four neighbouring words. Holding advance inactive keeps the same word, which acts as a wait state.

Read data flows straight from the array to the output in the same cycle as the edge that selects the word. No output register is added. An asynchronous output enable gates the data drivers and nothing else.

Writes can be done per lane. Each 9-bit lane is one data byte plus its parity bit. A global write forces a full-word write, whatever the per-lane controls say. Chip selects are sampled only on load cycles. A load with the selects not all asserted puts the core into a deselected power-down state, in which it neither drives data nor writes.

Top module: `sbsram_core`

## Requirements
- R1: After reset the core is deselected: `dataDrive` is 0 and `dataOut` is 0 until a selected read load occurs.
- R2: A controller-strobe load (`adscN` low, with no processor load qualified) is selected when `ce1N`=0, `ce2`=1 and `ce2bN`=0. With `gwN`=0 it writes all of `dataIn` to `addrIn` on that edge. A write cycle never drives data.
- R3: The lanes map as follows: lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. `bwN[k]` controls lane k. With `bweN`=0, exactly the lanes whose `bwN` bit is 0 are written, and the other lanes keep their old contents.
- R4: With `gwN`=1 and `bweN`=1, the `bwN` bits have no effect. The access is a read that writes nothing and drives the stored word.
- R5: With `gwN`=0, all four lanes are written, whatever the values of `bweN` and `bwN`.
- R6: A processor-strobe load (`adspN`=0 with `ce1N`=0) always reads at `addrIn`, and the word is valid after that same edge. It takes priority over `adscN` and ignores `gwN`, `bweN` and `bwN`.
- R7: `adspN` is ignored while `ce1N` is 1. With `adscN` also high, that cycle continues the current burst unchanged.
- R8: The chip selects are sampled only on load cycles. A load with `ce2`=0, `ce2bN`=1, or (for the controller strobe) `ce1N`=1 deselects the core. While deselected, it drives nothing and writes nothing until the next selected load.
- R9: With `advN`=0 on a non-load cycle, the burst address increments its two low bits and wraps modulo 4 inside the loaded base. From base low bits 2 the order is 2, 3, 0, 1, 2.
- R10: With `advN`=1 on a non-load cycle, the burst address is held (wait state).
- R11: `oeN` acts asynchronously. With `oeN`=1, `dataDrive` is 0 and `dataOut` is 0, and `oeN` never changes stored data or burst state.
- R12: A non-load cycle while selected writes at the current burst address if `gwN`=0, or if `bweN`=0 with any `bwN` bit low. Otherwise it reads there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control is captured on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 10 | External word address, used on load cycles |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| adspN | input | 1 | Processor load strobe, active low |
| adscN | input | 1 | Controller load strobe, active low |
| advN | input | 1 | Burst advance, active low; high inserts a wait state |
| ce1N | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Secondary chip select, active high |
| ce2bN | input | 1 | Tertiary chip select, active low |
| gwN | input | 1 | Global full-word write, active low |
| bweN | input | 1 | Lane-write gate, active low |
| bwN | input | 4 | Per-lane write enables, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 36 | Read data, 0 when not driven |
| dataDrive | output | 1 | High when the data drivers are on |

## Verification
A read starts at a load or a burst step, and its word appears at `dataOut` in the same cycle, after the capturing edge. No extra register stage is involved. A write lands on its capturing edge and can be seen from the next read load onward. An `oeN` change shows at the outputs within the same cycle, without any clock. The bench changes inputs 2 ns after each rising edge and samples the outputs at that same point, so each check observes the state that the most recent edge produced. The `oeN` checks sample 1 ns after the pin changes, with no clock edge in between.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

  // Strobes issued by the control unit to the datapath for one clock edge.
  typedef struct packed {
    logic load;      // take the external address
    logic step;      // advance the burst counter
    logic write;     // write at the effective address on this edge
    logic fullWord;  // write every lane, ignore per-lane enables
  } ctrlStrobes_t;

endpackage

// File: rtl/sbsram_ctrl.sv
`timescale 1ns/1ps
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce2bN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic                 oeN,
  output ctrlStrobes_t         strobes,
  output logic                 dataDrive
);

  logic active;     // selected by the last load
  logic readPhase;  // last edge performed a read while selected

  logic procLoad;
  logic ctrlLoad;
  logic anyLoad;
  logic selNow;
  logic nextActive;
  logic wrRequest;
  logic doWrite;

  // processor strobe only counts while the primary select is low
  assign procLoad = !adspN && !ce1N;
  assign ctrlLoad = !adscN && !procLoad;
  assign anyLoad  = procLoad || ctrlLoad;

  assign selNow     = !ce1N && ce2 && !ce2bN;
  assign nextActive = anyLoad ? selNow : active;

  assign wrRequest = !gwN || (!bweN && (bwN != {NUM_LANES{1'b1}}));
  assign doWrite   = nextActive && !procLoad && wrRequest;

  always_comb begin
    strobes          = '0;
    strobes.load     = anyLoad;
    strobes.step     = !anyLoad && !advN && active;
    strobes.write    = doWrite;
    strobes.fullWord = !gwN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      readPhase <= 1'b0;
    end else begin
      active    <= nextActive;
      readPhase <= nextActive && !doWrite;
    end
  end

  // output enable is asynchronous: it only gates the drivers
  assign dataDrive = readPhase && !oeN;

endmodule

// File: rtl/sbsram_dpath.sv
`timescale 1ns/1ps
module sbsram_dpath
  import sbsram_pkg::*;
#(
  parameter  int DEPTH      = 1024,
  parameter  int NUM_LANES  = 4,
  parameter  int LANE_W     = 9,
  parameter  int BURST_BITS = 2,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int DATA_W     = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 dataDrive,
  output logic [DATA_W-1:0]    dataOut
);

  logic [ADDR_W-1:0]     curAddr;
  logic [ADDR_W-1:0]     effAddr;
  logic [BURST_BITS-1:0] nextLow;
  logic [NUM_LANES-1:0]  laneMask;
  logic [DATA_W-1:0]     rdWord;

  assign nextLow = curAddr[BURST_BITS-1:0] + BURST_BITS'(1);

  // address used by this edge: new external, stepped (wrapping), or held
  always_comb begin
    if (strobes.load)
      effAddr = addrIn;
    else if (strobes.step)
      effAddr = {curAddr[ADDR_W-1:BURST_BITS], nextLow};
    else
      effAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curAddr <= '0;
    else       curAddr <= effAddr;
  end

  assign laneMask = strobes.fullWord ? {NUM_LANES{1'b1}} : ~bwN;

  // one storage array per lane so each lane has a single writer
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.write && laneMask[g])
        laneMem[effAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    // flow-through: array read straight from the registered address
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign dataOut = dataDrive ? rdWord : '0;

endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter  int DEPTH      = 1024,
  parameter  int NUM_LANES  = 4,
  parameter  int LANE_W     = 9,
  parameter  int BURST_BITS = 2,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int DATA_W     = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce2bN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic                 oeN,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataDrive
);

  ctrlStrobes_t strobes;

  sbsram_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .adspN     (adspN),
    .adscN     (adscN),
    .advN      (advN),
    .ce1N      (ce1N),
    .ce2       (ce2),
    .ce2bN     (ce2bN),
    .gwN       (gwN),
    .bweN      (bweN),
    .bwN       (bwN),
    .oeN       (oeN),
    .strobes   (strobes),
    .dataDrive (dataDrive)
  );

  sbsram_dpath #(
    .DEPTH      (DEPTH),
    .NUM_LANES  (NUM_LANES),
    .LANE_W     (LANE_W),
    .BURST_BITS (BURST_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrIn    (addrIn),
    .bwN       (bwN),
    .dataIn    (dataIn),
    .dataDrive (dataDrive),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/sbsram_chk.sv
`timescale 1ns/1ps
module sbsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              adspN,
  input logic              adscN,
  input logic              advN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce2bN,
  input logic              gwN,
  input logic              bweN,
  input logic              oeN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataDrive
);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> !oeN);

  // R11
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataDrive |-> (dataOut == '0));

  // R8
  proc_powerdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ce1N && (!ce2 || ce2bN)) |=> !dataDrive);

  // R8
  ctrl_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && !adscN && ce1N) |=> !dataDrive);

  // R6
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ce1N && ce2 && !ce2bN) |=> (oeN || dataDrive));

  // R2
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && !adscN && !ce1N && ce2 && !ce2bN && !gwN) |=> !dataDrive);

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && adscN && advN && gwN && bweN && dataDrive && !oeN)
      |=> (oeN || $stable(dataOut)));

endmodule

bind sbsram_core sbsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .adspN     (adspN),
  .adscN     (adscN),
  .advN      (advN),
  .ce1N      (ce1N),
  .ce2       (ce2),
  .ce2bN     (ce2bN),
  .gwN       (gwN),
  .bweN      (bweN),
  .oeN       (oeN),
  .dataOut   (dataOut),
  .dataDrive (dataDrive)
);

// File: tb/sbsram_core_bench.sv
`timescale 1ns/1ps
module sbsram_core_bench;

  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic ce1N = 1'b0, ce2 = 1'b1, ce2bN = 1'b0;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b0;
  logic [3:0]    bwN = 4'hF;
  logic [DW-1:0] dataOut;
  logic          dataDrive;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] refMem [1024];

  always #4 clk = ~clk;

  sbsram_core u_sbsram_core (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce2bN(ce2bN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    adspN = 1'b1; adscN = 1'b1; advN = 1'b1;
    ce1N = 1'b0; ce2 = 1'b1; ce2bN = 1'b0;
    gwN = 1'b1; bweN = 1'b1; bwN = 4'hF; oeN = 1'b0;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [3:0] laneLow);
    logic [DW-1:0] r = old;
    for (int k = 0; k < 4; k++)
      if (!laneLow[k]) r[k*9 +: 9] = nw[k*9 +: 9];
    return r;
  endfunction

  task automatic procRead(input logic [AW-1:0] a, input string req);
    idle();
    adspN = 1'b0; addrIn = a;
    step();
    check(req, {35'd0, dataDrive}, 36'd1);
    check(req, dataOut, refMem[a]);
    idle();
  endtask

  task automatic ctrlFullWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle();
    adscN = 1'b0; gwN = 1'b0; addrIn = a; dataIn = d;
    step();
    refMem[a] = d;
    check("R2 write cycle drives nothing", {35'd0, dataDrive}, 36'd0);
    idle();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1 reset drive", {35'd0, dataDrive}, 36'd0);
    check("R1 reset data", dataOut, 36'd0);
  endtask

  task automatic testFullWrite();
    ctrlFullWrite(10'd5, 36'h123456789);
    procRead(10'd5, "R2 full write readback");
    // R5: global write overrides lane gate and lane enables
    idle();
    adscN = 1'b0; gwN = 1'b0; bweN = 1'b1; bwN = 4'hF; addrIn = 10'd6; dataIn = 36'hABCDE0123;
    step();
    refMem[6] = 36'hABCDE0123;
    idle();
    procRead(10'd6, "R5 global write override");
  endtask

  task automatic testByteWrite();
    idle();
    adscN = 1'b0; bweN = 1'b0; bwN = 4'b1010; addrIn = 10'd5; dataIn = 36'hFFFFFFFFF;
    step();
    refMem[5] = merge(refMem[5], 36'hFFFFFFFFF, 4'b1010);
    idle();
    procRead(10'd5, "R3 lanes 0 and 2 written");
    idle();
    adscN = 1'b0; bweN = 1'b0; bwN = 4'b0111; addrIn = 10'd5; dataIn = 36'h000000000;
    step();
    refMem[5] = merge(refMem[5], 36'h0, 4'b0111);
    idle();
    procRead(10'd5, "R3 lane 3 written");
  endtask

  task automatic testLaneGate();
    logic [DW-1:0] keep = refMem[5];
    idle();
    adscN = 1'b0; bweN = 1'b1; bwN = 4'h0; addrIn = 10'd5; dataIn = 36'h0;
    step();
    check("R4 gate high read drive", {35'd0, dataDrive}, 36'd1);
    check("R4 gate high read data", dataOut, keep);
    idle();
    procRead(10'd5, "R4 nothing written");
  endtask

  task automatic testBurst();
    logic [DW-1:0] d [4] = '{36'h111111111, 36'h222222222, 36'h333333333, 36'h444444444};
    ctrlFullWrite(10'h12, d[0]);
    for (int i = 1; i < 4; i++) begin
      idle();
      advN = 1'b0; gwN = 1'b0; dataIn = d[i];
      step();
      check("R12 continue write drives nothing", {35'd0, dataDrive}, 36'd0);
    end
    refMem[10'h13] = d[1]; refMem[10'h10] = d[2]; refMem[10'h11] = d[3];
    idle();
    procRead(10'h12, "R9 burst base");
    advN = 1'b0; step();
    check("R9 step to 3", dataOut, d[1]);
    advN = 1'b1; step();
    check("R10 wait holds", dataOut, d[1]);
    advN = 1'b0; step();
    check("R9 wrap to 0", dataOut, d[2]);
    step();
    check("R9 step to 1", dataOut, d[3]);
    step();
    check("R9 back to base", dataOut, d[0]);
    idle();
  endtask

  task automatic testProcPriority();
    idle();
    adspN = 1'b0; adscN = 1'b0; gwN = 1'b0; bweN = 1'b0; bwN = 4'h0;
    addrIn = 10'd6; dataIn = 36'h0;
    step();
    check("R6 priority read drive", {35'd0, dataDrive}, 36'd1);
    check("R6 priority read data", dataOut, refMem[6]);
    idle();
    procRead(10'd6, "R6 no write by processor load");
  endtask

  task automatic testProcIgnored();
    procRead(10'd5, "R7 setup");
    adspN = 1'b0; ce1N = 1'b1; addrIn = 10'h12;
    step();
    check("R7 ignored load keeps drive", {35'd0, dataDrive}, 36'd1);
    check("R7 ignored load keeps word", dataOut, refMem[5]);
    idle();
  endtask

  task automatic testPowerDown();
    idle();
    adscN = 1'b0; ce2 = 1'b0; addrIn = 10'd5;
    step();
    check("R8 ce2 low deselect", {35'd0, dataDrive}, 36'd0);
    idle();
    ce2 = 1'b0; gwN = 1'b0; dataIn = 36'h0DEADBEEF;
    step();
    check("R8 deselected continue", {35'd0, dataDrive}, 36'd0);
    idle();
    procRead(10'd5, "R8 no write while deselected");
    idle();
    adspN = 1'b0; ce2bN = 1'b1; addrIn = 10'd5;
    step();
    check("R8 ce2bN high on processor load", {35'd0, dataDrive}, 36'd0);
    idle();
    adscN = 1'b0; ce1N = 1'b1; addrIn = 10'd5;
    step();
    check("R8 ce1N high on controller load", {35'd0, dataDrive}, 36'd0);
    idle();
  endtask

  task automatic testOe();
    procRead(10'd6, "R11 setup");
    oeN = 1'b1;
    #1;
    check("R11 oe high drive", {35'd0, dataDrive}, 36'd0);
    check("R11 oe high data", dataOut, 36'd0);
    step();
    oeN = 1'b0;
    #1;
    check("R11 oe low again drive", {35'd0, dataDrive}, 36'd1);
    check("R11 oe low again data", dataOut, refMem[6]);
    idle();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    testReset();
    testFullWrite();
    testByteWrite();
    testLaneGate();
    testBurst();
    testProcPriority();
    testProcIgnored();
    testPowerDown();
    testOe();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule